// File: doc/BRIEF.md
# UART Modem Control and Line Status

This block holds the modem control register and builds the line status register of one 16550-style UART channel. The CPU reaches both through a byte-wide register port. The modem control register drives three active-low pins: request-to-send, data-terminal-ready and one multi-function auxiliary pin. The auxiliary pin carries one of three signals, chosen by a 2-bit alternate-function select:

- the OUT2 control bit,
- the baud clock,
- an active-low receive-ready indication.

In internal loopback the OUT1 control bit drives the ring-indicator status bit that the modem status logic reports. In normal operation that bit follows the external ring input.

The line status register combines the following:

- live levels from the receiver and the transmitter,
- four sticky receive error flags (overrun, parity, framing, break), which set on one-cycle event pulses,
- a receive-FIFO error summary.

When any sticky error is set and the line status interrupt is enabled, an interrupt request is raised. The serializer, the FIFOs, the baud generator and the interrupt priority logic lie outside the block and appear only as ports.

Top module: `uart_mcls_top`

## Requirements
- R1: While `rst_ni` is low, the modem control register is 0, all four sticky error flags are 0, and `dtr_no`, `rts_no` and `aux_no` are all 1.
- R2: A write to offset 4 stores `wdata_i[4:0]`. From the next cycle, `dtr_no` equals the inverse of stored bit 0 and `rts_no` equals the inverse of stored bit 1.
- R3: With alternate select 0 or 3, `aux_no` equals the inverse of stored control bit 3 (OUT2).
- R4: With alternate select 1, `aux_no` follows `baud_clk_i`. With select 2, it equals the inverse of `rx_rdy_i`.
- R5: A read at offset 4 returns the stored control bits 4..0, with bits 7..5 reading 0.
- R6: When stored control bit 4 (loopback) is 1, `msr_ri_o` equals stored bit 2 (OUT1). Otherwise it equals `ri_i`.
- R7: A one-cycle pulse on `overrun_i`, `parity_err_i`, `framing_err_i` or `break_i` sets line status bit 1, 2, 3 or 4 respectively from the next cycle. `rls_irq_o` is 1 exactly when `rls_ie_i` is 1 and any of those four bits is set.
- R8: A read at offset 5 clears bits 1..4 from the next cycle. An error pulse in the same cycle as that read leaves its own bit set.
- R9: Line status bit 7 equals `fifo_mode_i AND rx_fifo_err_i`, so it is 0 in non-FIFO mode.
- R10: Line status bit 0 equals `rx_avail_i`, bit 5 equals `thr_empty_i`, and bit 6 equals `thr_empty_i AND tsr_empty_i`.
- R11: A write to offset 5 leaves every line status bit and the control register unchanged.
- R12: `rdata_o` is 0 when `rd_en_i` is low or when the offset is neither 4 nor 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register offset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| alt_sel_i | input | 2 | Auxiliary pin function select |
| baud_clk_i | input | 1 | Baud clock for the auxiliary pin |
| rx_rdy_i | input | 1 | Receive-ready indication |
| ri_i | input | 1 | Ring indicator status, active high |
| rx_avail_i | input | 1 | Receive data available |
| overrun_i | input | 1 | Overrun event pulse |
| parity_err_i | input | 1 | Parity error event pulse |
| framing_err_i | input | 1 | Framing error event pulse |
| break_i | input | 1 | Break event pulse |
| fifo_mode_i | input | 1 | FIFO mode enabled |
| rx_fifo_err_i | input | 1 | An errored character is in the receive FIFO |
| thr_empty_i | input | 1 | Holding register or transmit FIFO empty |
| tsr_empty_i | input | 1 | Transmit shift register empty |
| rls_ie_i | input | 1 | Line status interrupt enable |
| dtr_no | output | 1 | Data terminal ready, active low |
| rts_no | output | 1 | Request to send, active low |
| aux_no | output | 1 | Multi-function auxiliary pin |
| msr_ri_o | output | 1 | Ring-indicator status bit to modem status |
| rls_irq_o | output | 1 | Line status interrupt request |

## Verification
The bench builds the block with its default parameters: a 3-bit offset, control at offset 4, line status at offset 5, and the alternate-function multiplexer enabled. These defaults let the bench walk all four select codes, including the code 3 alias, and read back the unused offsets 0 and 7. With the multiplexer present, the bench can check the baud clock and receive-ready passing through the pin while OUT2 is held at the opposite level. It also checks the case where a read-clear and a fresh error pulse arrive in the same cycle.

// File: rtl/uart_mcls_pkg.sv
package uart_mcls_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned MCR_W  = 5;
  localparam int unsigned N_ERR  = 4;

  typedef enum logic [1:0] {
    ALT_OUT2  = 2'd0,
    ALT_BAUD  = 2'd1,
    ALT_RXRDY = 2'd2,
    ALT_RSVD  = 2'd3
  } alt_sel_e;

  // control bit positions
  localparam int unsigned MCR_DTR  = 0;
  localparam int unsigned MCR_RTS  = 1;
  localparam int unsigned MCR_OUT1 = 2;
  localparam int unsigned MCR_OUT2 = 3;
  localparam int unsigned MCR_LOOP = 4;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
    logic ovr;
  } err_evt_t;
endpackage

// File: rtl/mcls_mcr_reg.sv
module mcls_mcr_reg
  import uart_mcls_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ri_i,
  output logic [MCR_W-1:0]  mcr_o,
  output logic              dtr_no,
  output logic              rts_no,
  output logic              msr_ri_o
);
  logic [MCR_W-1:0] mcr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mcr_q <= '0;
    else if (we_i) mcr_q <= wdata_i[MCR_W-1:0];
  end

  assign mcr_o    = mcr_q;
  assign dtr_no   = ~mcr_q[MCR_DTR];
  assign rts_no   = ~mcr_q[MCR_RTS];
  // loopback replaces the ring input with OUT1
  assign msr_ri_o = mcr_q[MCR_LOOP] ? mcr_q[MCR_OUT1] : ri_i;
endmodule

// File: rtl/mcls_lsr.sv
module mcls_lsr
  import uart_mcls_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  err_evt_t          evt_i,
  input  logic              rx_avail_i,
  input  logic              thr_empty_i,
  input  logic              tsr_empty_i,
  input  logic              fifo_mode_i,
  input  logic              rx_fifo_err_i,
  input  logic              ie_i,
  output logic [N_ERR-1:0]  err_o,
  output logic [DATA_W-1:0] lsr_o,
  output logic              irq_o
);
  logic [N_ERR-1:0] evt_vec;
  logic [N_ERR-1:0] err_q;

  assign evt_vec = {evt_i.brk, evt_i.frm, evt_i.par, evt_i.ovr};

  for (genvar g = 0; g < N_ERR; g++) begin : g_sticky
    // set has priority over the read-clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         err_q[g] <= 1'b0;
      else if (evt_vec[g]) err_q[g] <= 1'b1;
      else if (clr_i)      err_q[g] <= 1'b0;
    end
  end

  assign err_o = err_q;
  assign lsr_o = {fifo_mode_i & rx_fifo_err_i,
                  thr_empty_i & tsr_empty_i,
                  thr_empty_i,
                  err_q,
                  rx_avail_i};
  assign irq_o = ie_i & (|err_q);
endmodule

// File: rtl/mcls_pin_mux.sv
module mcls_pin_mux
  import uart_mcls_pkg::*;
#(
  parameter bit ALT_EN = 1'b1
) (
  input  logic [1:0] sel_i,
  input  logic       out2_i,
  input  logic       baud_clk_i,
  input  logic       rx_rdy_i,
  output logic       pin_no
);
  if (ALT_EN) begin : g_alt
    always_comb begin
      unique case (alt_sel_e'(sel_i))
        ALT_BAUD:  pin_no = baud_clk_i;
        ALT_RXRDY: pin_no = ~rx_rdy_i;
        default:   pin_no = ~out2_i;
      endcase
    end
  end else begin : g_fixed
    logic unused_alt;
    assign unused_alt = ^{sel_i, baud_clk_i, rx_rdy_i};
    assign pin_no     = ~out2_i;
  end
endmodule

// File: rtl/uart_mcls_top.sv
module uart_mcls_top
  import uart_mcls_pkg::*;
#(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned MCR_ADDR = 4,
  parameter int unsigned LSR_ADDR = 5,
  parameter bit          ALT_EN   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [1:0]        alt_sel_i,
  input  logic              baud_clk_i,
  input  logic              rx_rdy_i,
  input  logic              ri_i,
  input  logic              rx_avail_i,
  input  logic              overrun_i,
  input  logic              parity_err_i,
  input  logic              framing_err_i,
  input  logic              break_i,
  input  logic              fifo_mode_i,
  input  logic              rx_fifo_err_i,
  input  logic              thr_empty_i,
  input  logic              tsr_empty_i,
  input  logic              rls_ie_i,
  output logic              dtr_no,
  output logic              rts_no,
  output logic              aux_no,
  output logic              msr_ri_o,
  output logic              rls_irq_o
);
  localparam logic [ADDR_W-1:0] A_MCR = ADDR_W'(MCR_ADDR);
  localparam logic [ADDR_W-1:0] A_LSR = ADDR_W'(LSR_ADDR);

  logic             sel_mcr, sel_lsr;
  logic [MCR_W-1:0] mcr_val;
  logic [N_ERR-1:0] err_flags;
  logic [7:0]       lsr_val;
  err_evt_t         evt;

  assign sel_mcr = (addr_i == A_MCR);
  assign sel_lsr = (addr_i == A_LSR);
  assign evt     = '{brk: break_i, frm: framing_err_i, par: parity_err_i, ovr: overrun_i};

  mcls_mcr_reg u_mcr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i & sel_mcr),
    .wdata_i (wdata_i),
    .ri_i    (ri_i),
    .mcr_o   (mcr_val),
    .dtr_no  (dtr_no),
    .rts_no  (rts_no),
    .msr_ri_o(msr_ri_o)
  );

  mcls_lsr u_lsr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (rd_en_i & sel_lsr),
    .evt_i        (evt),
    .rx_avail_i   (rx_avail_i),
    .thr_empty_i  (thr_empty_i),
    .tsr_empty_i  (tsr_empty_i),
    .fifo_mode_i  (fifo_mode_i),
    .rx_fifo_err_i(rx_fifo_err_i),
    .ie_i         (rls_ie_i),
    .err_o        (err_flags),
    .lsr_o        (lsr_val),
    .irq_o        (rls_irq_o)
  );

  mcls_pin_mux #(.ALT_EN(ALT_EN)) u_mux (
    .sel_i     (alt_sel_i),
    .out2_i    (mcr_val[MCR_OUT2]),
    .baud_clk_i(baud_clk_i),
    .rx_rdy_i  (rx_rdy_i),
    .pin_no    (aux_no)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (sel_mcr)      rdata_o = {{(8-MCR_W){1'b0}}, mcr_val};
      else if (sel_lsr) rdata_o = lsr_val;
    end
  end
endmodule

// File: rtl/mcls_checks.sv
module mcls_checks #(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned MCR_ADDR = 4,
  parameter int unsigned LSR_ADDR = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic              overrun_i,
  input logic              parity_err_i,
  input logic              framing_err_i,
  input logic              break_i,
  input logic              rls_ie_i,
  input logic              rls_irq_o,
  input logic              dtr_no,
  input logic              rts_no,
  input logic [3:0]        err_flags
);
  logic any_evt;
  assign any_evt = overrun_i | parity_err_i | framing_err_i | break_i;

  p_dtr_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(MCR_ADDR)) |=> (dtr_no == !$past(wdata_i[0])));

  p_rts_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(MCR_ADDR)) |=> (rts_no == !$past(wdata_i[1])));

  p_mcr_upper_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADDR_W'(MCR_ADDR)) |-> (rdata_o[7:5] == 3'b000));

  p_parity_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parity_err_i |=> err_flags[1]);

  p_irq_follows_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (break_i && rls_ie_i) |=> (rls_irq_o || !rls_ie_i));

  p_read_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADDR_W'(LSR_ADDR) && !any_evt) |=> (err_flags == 4'b0000));

  p_lsr_write_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(LSR_ADDR) && !rd_en_i && !any_evt) |=> $stable(err_flags));

  p_other_addr_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != ADDR_W'(MCR_ADDR) && addr_i != ADDR_W'(LSR_ADDR)) |-> (rdata_o == 8'h00));
endmodule

bind uart_mcls_top mcls_checks #(
  .ADDR_W(ADDR_W), .MCR_ADDR(MCR_ADDR), .LSR_ADDR(LSR_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .overrun_i(overrun_i), .parity_err_i(parity_err_i),
  .framing_err_i(framing_err_i), .break_i(break_i),
  .rls_ie_i(rls_ie_i), .rls_irq_o(rls_irq_o),
  .dtr_no(dtr_no), .rts_no(rts_no), .err_flags(err_flags)
);

// File: tb/tb_uart_mcls_top.sv
module tb_uart_mcls_top;
  localparam int CLK_P = 10;

  logic       clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic       wr = 0, rd = 0;
  logic [7:0] wdata = 0, rdata;
  logic [1:0] alt = 0;
  logic baud = 0, rxr = 0, ri = 0, dr = 0;
  logic ovr = 0, par = 0, frm = 0, brk = 0;
  logic fmode = 0, ferr = 0, thr = 1, tsr = 1, ie = 0;
  logic dtr_n, rts_n, aux_n, ri_o, irq;

  int tests = 0, fails = 0;
  int m_mcr = 0, m_err = 0;
  string tag = "R1";

  always #(CLK_P/2) clk = ~clk;

  uart_mcls_top dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .rd_en_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .alt_sel_i(alt), .baud_clk_i(baud),
    .rx_rdy_i(rxr), .ri_i(ri), .rx_avail_i(dr), .overrun_i(ovr),
    .parity_err_i(par), .framing_err_i(frm), .break_i(brk),
    .fifo_mode_i(fmode), .rx_fifo_err_i(ferr), .thr_empty_i(thr),
    .tsr_empty_i(tsr), .rls_ie_i(ie), .dtr_no(dtr_n), .rts_no(rts_n),
    .aux_no(aux_n), .msr_ri_o(ri_o), .rls_irq_o(irq)
  );

  // reference model: state update
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mcr = 0; m_err = 0;
    end else begin
      int ev;
      ev = (ovr ? 1 : 0) + (par ? 2 : 0) + (frm ? 4 : 0) + (brk ? 8 : 0);
      if (rd && addr == 5) m_err = 0;
      m_err = m_err | ev;
      if (wr && addr == 4) m_mcr = wdata % 32;
    end
  end

  task automatic chk(string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    int lsr, e_rd, e_aux, e_ri;
    lsr = (fmode && ferr ? 128 : 0) + (thr && tsr ? 64 : 0) + (thr ? 32 : 0)
        + m_err * 2 + (dr ? 1 : 0);
    e_rd = !rd ? 0 : (addr == 4) ? m_mcr : (addr == 5) ? lsr : 0;
    case (alt)
      1:       e_aux = baud;
      2:       e_aux = !rxr;
      default: e_aux = ((m_mcr / 8) % 2) ? 0 : 1;
    endcase
    e_ri = ((m_mcr / 16) % 2) ? (m_mcr / 4) % 2 : ri;
    chk("rdata", rdata, e_rd);
    chk("dtr_no", dtr_n, (m_mcr % 2) ? 0 : 1);
    chk("rts_no", rts_n, ((m_mcr / 2) % 2) ? 0 : 1);
    chk("aux_no", aux_n, e_aux);
    chk("msr_ri", ri_o, e_ri);
    chk("irq", irq, (ie && m_err != 0) ? 1 : 0);
  endtask

  // one cycle: inputs already set after negedge; compare, then advance
  task automatic cyc();
    #1 compare();
    @(negedge clk);
  endtask

  task automatic idle();
    wr = 0; rd = 0; ovr = 0; par = 0; frm = 0; brk = 0;
  endtask

  task automatic wr_reg(int a, int d);
    addr = 3'(a); wdata = 8'(d); wr = 1; cyc(); idle();
  endtask

  task automatic rd_reg(int a);
    addr = 3'(a); rd = 1; cyc(); idle();
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    tag = "R1"; rd = 1; addr = 4; cyc(); cyc(); addr = 5; cyc(); idle();
    rst_n = 1; rd_reg(4); rd_reg(5);

    tag = "R2"; wr_reg(4, 8'h01); rd_reg(4); wr_reg(4, 8'h02); rd_reg(4);
    wr_reg(4, 8'h03); rd_reg(4);

    tag = "R3"; alt = 0; wr_reg(4, 8'h08); rd_reg(4); alt = 3; cyc();
    wr_reg(4, 8'h00); cyc(); alt = 0; cyc();

    tag = "R4"; wr_reg(4, 8'h08); alt = 1;
    for (int i = 0; i < 4; i++) begin baud = ~baud; cyc(); end
    alt = 2;
    for (int i = 0; i < 4; i++) begin rxr = ~rxr; cyc(); end
    alt = 0; cyc();

    tag = "R5"; wr_reg(4, 8'hFF); rd_reg(4); wr_reg(4, 8'hE0); rd_reg(4);

    tag = "R6"; ri = 1; wr_reg(4, 8'h10); cyc(); wr_reg(4, 8'h14); ri = 0; cyc();
    ri = 1; cyc(); wr_reg(4, 8'h04); cyc(); ri = 0; cyc(); wr_reg(4, 8'h00);

    tag = "R7"; ie = 0; ovr = 1; cyc(); idle(); cyc(); rd_reg(5);
    ie = 1; par = 1; cyc(); idle(); cyc(); frm = 1; cyc(); idle(); rd_reg(5);
    brk = 1; cyc(); idle(); cyc(); ie = 0; cyc(); ie = 1; cyc();

    tag = "R8"; rd_reg(5); cyc(); rd_reg(5);
    par = 1; cyc(); idle();
    addr = 5; rd = 1; frm = 1; cyc(); idle(); rd_reg(5); rd_reg(5);

    tag = "R9"; fmode = 0; ferr = 1; rd_reg(5); fmode = 1; rd_reg(5);
    ferr = 0; rd_reg(5); fmode = 0; rd_reg(5);

    tag = "R10";
    for (int i = 0; i < 8; i++) begin
      thr = i[0]; tsr = i[1]; dr = i[2]; rd_reg(5);
    end
    thr = 1; tsr = 1; dr = 0;

    tag = "R11"; brk = 1; cyc(); idle();
    wr_reg(5, 8'hFF); rd_reg(5); wr_reg(5, 8'h00); rd_reg(5); rd_reg(4);

    tag = "R12"; rd_reg(0); rd_reg(7); rd_reg(3); addr = 4; cyc(); addr = 5; cyc();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule